// File: doc/BRIEF.md
# Power-of-Two Scale Operand Generator

This block turns a signed 32-bit exponent adjustment `p` into the bit pattern of the floating-point value 2^p, in a format picked per request: single (8-bit exponent, 23-bit fraction), double (11-bit exponent, 52-bit fraction) or 80-bit extended (15-bit exponent, 64-bit significand with an explicit integer bit). A multiplier placed after it multiplies another operand by that pattern, which scales that operand by a power of two. The multiplier is not part of this block.

Each format has three result regions. Exponents above the bias saturate to infinity. Exponents in the normal range give a biased exponent field and an empty fraction. Exponents at or below minus the bias clear the exponent field and place a single fraction bit, so the block can form subnormal powers of two. Adjustments that lie deeper still give a zero pattern. A request is a one-cycle `in_valid` pulse. The result is registered: it appears with `out_valid` one clock later and stays unchanged until the next request.

Top module: `pow2_scale_gen`

## Requirements
- R1: After reset `out_valid` is 0 and `out_bits` is all zeros. `out_valid` is 1 in exactly the cycle after a cycle with `in_valid` high, and 0 after a cycle with `in_valid` low.
- R2: While `in_valid` is low, `out_bits` keeps its last value whatever `in_fmt` and `in_exp` do.
- R3: Format code `in_fmt` = 0 selects single, 1 selects double and 2 selects extended. For -bias < p <= bias, where bias is 127, 1023 or 16383, the exponent field holds bias+p and the fraction is zero. Single uses exponent bits [30:23] and fraction bits [22:0]. Double uses exponent bits [62:52] and fraction bits [51:0].
- R4: For p > bias the exponent field is all ones and the fraction is zero, which encodes +infinity.
- R5: For p <= -bias the exponent field is zero. The block forms k = p + bias + F - 1, with F = 23, 52 or 63. If 0 <= k < F, only fraction bit k is set.
- R6: In the region of R5, k = -1 gives a fraction of exactly 1, and k < -1 gives an all-zero pattern.
- R7: In extended format the exponent sits in bits [78:64], bit 63 is the explicit integer bit and bits [62:0] are the fraction. Bit 63 is 1 for normal and infinite results and 0 for subnormal and zero results.
- R8: Format code 3 is reserved and yields an all-zero `out_bits`.
- R9: The sign bit of the chosen format is always 0. Bits of `out_bits` above the chosen format's width are 0.
- R10: Every 32-bit `p`, including -2^31 and 2^31-1, is classified with no arithmetic wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe, one request per high cycle |
| in_fmt | input | 2 | Format code: 0 single, 1 double, 2 extended, 3 reserved |
| in_exp | input | 32 | Signed exponent adjustment p |
| out_valid | output | 1 | High for one cycle when a new result is present |
| out_bits | output | 80 | Result pattern, right-aligned and zero-extended |

## Verification
The hardest inputs to reach are the narrow subnormal band and the single value k = -1 just below it. For extended format this band is 64 values of `p` near -16445, out of a 2^32 input space, so uniform random inputs almost never land in it. The stimulus therefore picks, per vector, a base at each format's ±bias or at its bottom subnormal edge and adds a small random offset. It also applies the exact edge values as directed cases, together with the two extreme 32-bit inputs.

// File: rtl/pow2_pkg.sv
// Package: shared format constants and region type for the power-of-two
// scale operand generator. Assumes the three formats are fixed; only the
// input exponent width is a free choice.
package pow2_pkg;
    localparam int EXP_IN_W = 32;             // width of the signed adjustment
    localparam int WIDE_W   = EXP_IN_W + 2;   // headroom for bias and offsets
    localparam int OUT_W    = 80;             // widest result pattern

    localparam int SP_EW = 8;
    localparam int SP_FW = 23;
    localparam int DP_EW = 11;
    localparam int DP_FW = 52;
    localparam int XP_EW = 15;
    localparam int XP_FW = 63;                 // fraction bits below the integer bit

    localparam int SP_W = 1 + SP_EW + SP_FW;
    localparam int DP_W = 1 + DP_EW + DP_FW;
    localparam int XP_W = 1 + XP_EW + XP_FW + 1;

    typedef enum logic [1:0] {
        FMT_SINGLE   = 2'd0,
        FMT_DOUBLE   = 2'd1,
        FMT_EXTENDED = 2'd2,
        FMT_RESERVED = 2'd3
    } fmt_t;

    typedef enum logic [1:0] {
        RGN_SUB  = 2'd0,
        RGN_NORM = 2'd1,
        RGN_INF  = 2'd2
    } region_t;
endpackage

// File: rtl/pow2_subnorm_shift.sv
// Module: one-hot fraction builder for the subnormal region.
// Sets bit k of the fraction when 0 <= k < FW, and sets bit 0 as well when
// k == -1. Any other k gives zero. Assumes k is a signed WIDE_W value.
module pow2_subnorm_shift #(
    parameter int FW = 23,
    parameter int KW = 34
) (
    input  logic signed [KW-1:0] k_pos,
    output logic [FW-1:0]        frac
);
    localparam logic signed [KW-1:0] MINUS_ONE = -1;

    // one comparator per fraction bit
    for (genvar i = 0; i < FW; i++) begin : g_bit
        localparam logic signed [KW-1:0] IDX = KW'(i);
        if (i == 0) begin : g_lsb
            assign frac[i] = (k_pos == IDX) || (k_pos == MINUS_ONE);
        end else begin : g_upper
            assign frac[i] = (k_pos == IDX);
        end
    end
endmodule

// File: rtl/pow2_lane.sv
// Module: bit pattern of 2^p for one format.
// It classifies p into the infinity, normal or subnormal region and builds
// {sign=0, exponent, [integer bit], fraction}. Assumes p_wide is p
// sign-extended to WIDE_W bits, so adding the bias and offsets cannot wrap.
module pow2_lane #(
    parameter int EW       = 8,
    parameter int FW       = 23,
    parameter int EXPLICIT = 0,
    parameter int KW       = 34,
    parameter int W        = 1 + EW + FW + EXPLICIT
) (
    input  logic signed [KW-1:0] p_wide,
    output logic [W-1:0]         pattern
);
    import pow2_pkg::*;

    localparam int BIAS = ((1 << EW) - 1) >> 1;
    localparam logic signed [KW-1:0] BIAS_S = KW'(BIAS);
    localparam logic signed [KW-1:0] NBIAS_S = -BIAS_S;
    localparam logic signed [KW-1:0] K_OFF = KW'(BIAS + FW - 1);

    region_t             region;
    logic signed [KW-1:0] k_pos;
    logic [FW-1:0]       sub_frac;
    logic [FW-1:0]       frac;
    logic [EW-1:0]       exp_fld;

    // pick the result region from the signed adjustment
    always_comb begin
        if (p_wide > BIAS_S)       region = RGN_INF;
        else if (p_wide > NBIAS_S) region = RGN_NORM;
        else                       region = RGN_SUB;
    end

    // position of the single fraction bit in the subnormal region
    assign k_pos = p_wide + K_OFF;

    pow2_subnorm_shift #(.FW(FW), .KW(KW)) u_shift (
        .k_pos (k_pos),
        .frac  (sub_frac)
    );

    // exponent field and fraction for each region
    always_comb begin
        unique case (region)
            RGN_INF:  begin exp_fld = '1;                     frac = '0;       end
            RGN_NORM: begin exp_fld = EW'(p_wide + BIAS_S);   frac = '0;       end
            default:  begin exp_fld = '0;                     frac = sub_frac; end
        endcase
    end

    // pack the fields, with the integer bit only when the format has one
    if (EXPLICIT != 0) begin : g_explicit
        logic int_bit;
        assign int_bit = (region != RGN_SUB);
        assign pattern = {1'b0, exp_fld, int_bit, frac};
    end else begin : g_hidden
        assign pattern = {1'b0, exp_fld, frac};
    end
endmodule

// File: rtl/pow2_select.sv
// Module: format selector. Zero-extends the chosen lane's pattern to the
// output width, and gives zero for the reserved code.
module pow2_select #(
    parameter int OW = 80,
    parameter int SW = 32,
    parameter int DW = 64,
    parameter int XW = 80
) (
    input  pow2_pkg::fmt_t  fmt,
    input  logic [SW-1:0]   pat_s,
    input  logic [DW-1:0]   pat_d,
    input  logic [XW-1:0]   pat_x,
    output logic [OW-1:0]   pat_out
);
    import pow2_pkg::*;

    // route the requested format to the output
    always_comb begin
        unique case (fmt)
            FMT_SINGLE:   pat_out = OW'(pat_s);
            FMT_DOUBLE:   pat_out = OW'(pat_d);
            FMT_EXTENDED: pat_out = OW'(pat_x);
            default:      pat_out = '0;
        endcase
    end
endmodule

// File: rtl/pow2_scale_gen.sv
// Module: top of the power-of-two scale operand generator.
// It widens p, runs one lane per format, selects the requested one and
// registers it with a valid strobe. Assumes one request per in_valid cycle,
// with no back-pressure. The output holds between requests.
module pow2_scale_gen (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [1:0]  in_fmt,
    input  logic [31:0] in_exp,
    output logic        out_valid,
    output logic [79:0] out_bits
);
    import pow2_pkg::*;

    logic signed [WIDE_W-1:0] p_wide;
    logic [SP_W-1:0]  pat_s;
    logic [DP_W-1:0]  pat_d;
    logic [XP_W-1:0]  pat_x;
    logic [OUT_W-1:0] pat_sel;
    fmt_t             fmt;

    // sign-extend p so later sums cannot overflow
    assign p_wide = {{(WIDE_W-EXP_IN_W){in_exp[EXP_IN_W-1]}}, in_exp};
    assign fmt    = fmt_t'(in_fmt);

    pow2_lane #(.EW(SP_EW), .FW(SP_FW), .EXPLICIT(0), .KW(WIDE_W)) u_lane_s (
        .p_wide  (p_wide),
        .pattern (pat_s)
    );
    pow2_lane #(.EW(DP_EW), .FW(DP_FW), .EXPLICIT(0), .KW(WIDE_W)) u_lane_d (
        .p_wide  (p_wide),
        .pattern (pat_d)
    );
    pow2_lane #(.EW(XP_EW), .FW(XP_FW), .EXPLICIT(1), .KW(WIDE_W)) u_lane_x (
        .p_wide  (p_wide),
        .pattern (pat_x)
    );

    pow2_select #(.OW(OUT_W), .SW(SP_W), .DW(DP_W), .XW(XP_W)) u_sel (
        .fmt     (fmt),
        .pat_s   (pat_s),
        .pat_d   (pat_d),
        .pat_x   (pat_x),
        .pat_out (pat_sel)
    );

    // output register: capture on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bits  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_bits <= pat_sel;
        end
    end
endmodule

// File: rtl/pow2_scale_chk.sv
// Checker: temporal properties of pow2_scale_gen, seen at its ports.
module pow2_scale_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [1:0]  in_fmt,
    input logic [31:0] in_exp,
    input logic        out_valid,
    input logic [79:0] out_bits
);
    // R1: valid follows a request by one cycle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R2: no request, no change
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_bits));
    // R4: double overflow gives infinity
    a_r4_dbl_inf: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_fmt) == 2'd1 && $signed($past(in_exp)) > 32'sd1023)
        |-> (out_bits[62:52] == 11'h7FF && out_bits[51:0] == 52'd0));
    // R7: integer bit set exactly when the extended exponent is non-zero
    a_r7_int_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_fmt) == 2'd2) |-> ((out_bits[78:64] != 15'd0) == out_bits[63]));
    // R8: reserved code gives zero
    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_fmt) == 2'd3) |-> (out_bits == 80'd0));
    // R9: single result has clear sign and clear upper bits
    a_r9_single_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_fmt) == 2'd0) |-> (out_bits[79:31] == 49'd0));
endmodule

bind pow2_scale_gen pow2_scale_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_fmt    (in_fmt),
    .in_exp    (in_exp),
    .out_valid (out_valid),
    .out_bits  (out_bits)
);

// File: tb/sim_pow2_scale_gen.sv
module sim_pow2_scale_gen;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_fmt = 2'd0;
    logic [31:0] in_exp = 32'd0;
    logic        out_valid;
    logic [79:0] out_bits;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pow2_scale_gen u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_fmt(in_fmt),
        .in_exp(in_exp), .out_valid(out_valid), .out_bits(out_bits)
    );

    // reference pattern built straight from the requirements
    function automatic logic [79:0] ref_pat(logic [1:0] f, int p);
        longint ew, fw, bias, k, e;
        logic [63:0] frac;
        logic ib;
        bit expl;
        logic [79:0] r;
        case (f)
            2'd0: begin ew = 8;  fw = 23; expl = 0; end
            2'd1: begin ew = 11; fw = 52; expl = 0; end
            2'd2: begin ew = 15; fw = 63; expl = 1; end
            default: return 80'd0;                       // R8
        endcase
        bias = ((longint'(1) << ew) - 1) >>> 1;
        if (longint'(p) > bias) begin                    // R4
            e = (longint'(1) << ew) - 1; frac = 0; ib = 1'b1;
        end else if (longint'(p) > -bias) begin          // R3
            e = bias + longint'(p); frac = 0; ib = 1'b1;
        end else begin                                   // R5, R6
            e = 0; ib = 1'b0;
            k = longint'(p) + bias + fw - 1;
            if (k >= 0 && k < fw) frac = 64'd1 << k;
            else frac = (k == -1) ? 64'd1 : 64'd0;
        end
        r = 80'(frac) | (80'(e) << (fw + (expl ? 1 : 0)));
        if (expl) r[63] = ib;                            // R7
        return r;
    endfunction

    task automatic check(string tag, logic [79:0] act, logic [79:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one request, result checked at the negedge after the capturing edge
    task automatic apply(logic [1:0] f, int p, string tag);
        logic [79:0] exp;
        exp = ref_pat(f, p);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = f; in_exp = p;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 valid"}, 80'(out_valid), 80'd1);
        check({tag, " fmt/p=", $sformatf("%0d/%0d", f, p)}, out_bits, exp);
    endtask

    int watch = 0;
    initial begin
        while (watch < 200000) begin
            @(posedge clk);
            watch++;
        end
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [79:0] held;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset valid", 80'(out_valid), 80'd0);
        check("R1 reset bits", out_bits, 80'd0);
        rst_n = 1'b1;

        // R3 normal range
        apply(2'd0, 0, "R3");
        check("R3 one single", out_bits, 80'h3F800000);
        apply(2'd0, 127, "R3");
        apply(2'd0, -126, "R3");
        apply(2'd1, 0, "R3");
        check("R3 one double", out_bits, 80'h3FF0000000000000);
        // R4 overflow
        apply(2'd0, 128, "R4");
        check("R4 inf single", out_bits, 80'h7F800000);
        apply(2'd1, 1024, "R4");
        // R5 subnormal bits
        apply(2'd0, -127, "R5");
        check("R5 top sub", out_bits, 80'h00400000);
        apply(2'd0, -149, "R5");
        apply(2'd1, -1074, "R5");
        // R6 k = -1 and deeper
        apply(2'd0, -150, "R6");
        check("R6 k=-1 single", out_bits, 80'h1);
        apply(2'd0, -151, "R6");
        check("R6 deep zero", out_bits, 80'h0);
        apply(2'd1, -1075, "R6");
        // R7 extended
        apply(2'd2, 0, "R7");
        check("R7 one ext", out_bits, 80'h3FFF8000000000000000);
        apply(2'd2, 16384, "R7");
        check("R7 inf ext", out_bits, 80'h7FFF8000000000000000);
        apply(2'd2, -16383, "R7");
        check("R7 top sub ext", out_bits, 80'h00004000000000000000);
        apply(2'd2, -16446, "R7");
        // R8 reserved
        apply(2'd3, 5, "R8");
        // R10 extremes
        for (int f = 0; f < 4; f++) begin
            apply(2'(f), 32'h7FFFFFFF, "R10");
            apply(2'(f), 32'h80000000, "R10");
        end

        // R2: output holds while idle inputs move
        apply(2'd1, 7, "R2 setup");
        held = out_bits;
        in_fmt = 2'd0; in_exp = 32'hFFFF0000;
        @(negedge clk);
        check("R2 hold bits", out_bits, held);
        check("R1 idle valid", 80'(out_valid), 80'd0);

        // constrained random near region edges, plus full-range draws (R9)
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] f;
            int base, p;
            f = 2'($urandom_range(0, 3));
            case ($urandom_range(0, 4))
                0: base = 127;
                1: base = -1023;
                2: base = (f == 2'd2) ? -16445 : ((f == 2'd1) ? -1074 : -149);
                3: base = (f == 2'd2) ? 16383 : -127;
                default: base = 0;
            endcase
            if ($urandom_range(0, 5) == 0) p = int'($urandom());
            else p = base + int'($urandom_range(0, 140)) - 70;
            apply(f, p, "R9 rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule